// File: doc/BRIEF.md
# Thermal Warning Output Limiter

This block reacts to an active-low thermal warning coming from the power output stage. When the warning stays present for longer than a qualification window of millisecond ticks, the block pulls the modulation limit down from the normal maximum to a programmable -3 dB coefficient. The aim is to bring the stage back out of its warning condition. The coefficient comes in on a port from the surrounding coefficient storage. The block drives out a limit-active flag and the limit value that the modulator should use.

Two control bits set the policy. The adjustment-disable bit switches the whole mechanism off. The latch-limit bit chooses between two behaviours once the warning goes away: the limit is either lifted and full gain restored, or it stays in force until software clears the bit. Both bits come out of reset set. The warning input passes through a two-flop synchronizer. The qualification timer counts a 1 ms tick enable, so the window does not depend on the system clock.

Top module: `thermal_limiter`

## Requirements
- R1: After synchronous reset, `ctl_rdata` reads 0x60, which means bit 6 (adjustment disable) = 1 and bit 5 (latch limit) = 1. `limit_on` is 0 and `limit_val` is all ones.
- R2: `warn_n` is active low and passes through a two-flop synchronizer. While the synchronized warning is present and adjustment is enabled, each `tick_ms` pulse advances a timer. `limit_on` rises at the clock edge that counts tick number QUAL_TICKS+1 of an unbroken warning.
- R3: If the synchronized warning disappears before qualification, the timer returns to zero, and a later warning needs QUAL_TICKS+1 fresh ticks.
- R4: Without `tick_ms` pulses the timer does not advance, however long the warning lasts.
- R5: `limit_val` is registered. It equals the value `lim_coef` had at the previous edge while `limit_on` is 1, and it is all ones while `limit_on` is 0.
- R6: While bit 6 = 1, no limit is applied. If bit 6 is set while a limit is active, the limit is dropped at the next edge and the timer is cleared.
- R7: With bit 6 = 0 and bit 5 = 0, an active limit is released one edge after the synchronized warning clears.
- R8: With bit 6 = 0 and bit 5 = 1, an active limit stays after the warning clears. It is released only once bit 5 is written to 0 (with the warning clear) or by reset.
- R9: A write with `ctl_we` = 1 loads bits 6 and 5 of `ctl_wdata` at the clock edge. All other read bits are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle 1 ms tick enable |
| warn_n | input | 1 | Thermal warning from the power stage, active low |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data (bit 6 adjustment disable, bit 5 latch limit) |
| lim_coef | input | LIM_W | Programmable -3 dB limit coefficient |
| ctl_rdata | output | 8 | Control register readback |
| limit_on | output | 1 | Reduced limit is in force |
| limit_val | output | LIM_W | Selected modulation limit |

## Verification
A corrupted qualification timer shows at the ports only as a wrong edge for the rise of `limit_on`. The fault can stay hidden for up to QUAL_TICKS+1 ticks, so the bench compares against a reference model on every cycle and runs warnings that end just short of the threshold, just past it, and with sparse ticks. A wrong latch or bypass state appears within one edge of the warning clearing or of a control write, as a `limit_on` level or a `limit_val` that differs from the model. A wrong register bit shows at once on `ctl_rdata`.

// File: rtl/thermal_limiter.sv
module thermal_limiter #(
  parameter int QUAL_TICKS = 400,
  parameter int LIM_W      = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_ms,
  input  logic             warn_n,
  input  logic             ctl_we,
  input  logic [7:0]       ctl_wdata,
  input  logic [LIM_W-1:0] lim_coef,
  output logic [7:0]       ctl_rdata,
  output logic             limit_on,
  output logic [LIM_W-1:0] limit_val
);
  localparam int CNT_W = $clog2(QUAL_TICKS + 1);
  localparam logic [CNT_W-1:0] QUAL_C = CNT_W'(QUAL_TICKS);
  localparam int ADJ_BIT = 6;
  localparam int LAT_BIT = 5;

  logic             adj_off, latch_en;
  logic [1:0]       sync_q;
  logic [CNT_W-1:0] cnt;
  logic             warn, qualify, release_ok, lim_nxt;

  assign warn       = ~sync_q[1];
  assign qualify    = tick_ms & warn & (cnt == QUAL_C);
  assign release_ok = ~warn & ~latch_en;
  assign lim_nxt    = ~adj_off & (limit_on ? ~release_ok : qualify);

  always_ff @(posedge clk) begin
    if (rst) begin
      adj_off  <= 1'b1;
      latch_en <= 1'b1;
    end else if (ctl_we) begin
      adj_off  <= ctl_wdata[ADJ_BIT];
      latch_en <= ctl_wdata[LAT_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b11;
    else     sync_q <= {sync_q[0], warn_n};
  end

  always_ff @(posedge clk) begin
    if (rst || adj_off || limit_on || !warn || qualify) cnt <= '0;
    else if (tick_ms)                                   cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      limit_on  <= 1'b0;
      limit_val <= '1;
    end else begin
      limit_on  <= lim_nxt;
      limit_val <= lim_nxt ? lim_coef : '1;
    end
  end

  always_comb begin
    ctl_rdata          = '0;
    ctl_rdata[ADJ_BIT] = adj_off;
    ctl_rdata[LAT_BIT] = latch_en;
  end
endmodule

module thermal_limiter_chk #(
  parameter int QUAL_TICKS = 400,
  parameter int LIM_W      = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_ms,
  input logic             warn_s,
  input logic [7:0]       ctl_rdata,
  input logic [LIM_W-1:0] lim_coef,
  input logic             limit_on,
  input logic [LIM_W-1:0] limit_val,
  input logic [$clog2(QUAL_TICKS+1)-1:0] cnt
);
  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (!limit_on && ctl_rdata == 8'h60 && limit_val == '1)); // R1
  AST_RISE_NEEDS_WARN: assert property (@(posedge clk) disable iff (rst) $rose(limit_on) |-> !$past(warn_s)); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst) cnt <= ($clog2(QUAL_TICKS+1))'(QUAL_TICKS)); // R3
  AST_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst) $rose(limit_on) |-> $past(tick_ms)); // R4
  AST_VAL_COEF: assert property (@(posedge clk) disable iff (rst) limit_on |-> limit_val == $past(lim_coef)); // R5
  AST_VAL_FULL: assert property (@(posedge clk) disable iff (rst) !limit_on |-> limit_val == '1); // R5
  AST_BYPASS_DROP: assert property (@(posedge clk) disable iff (rst) ctl_rdata[6] |=> !limit_on); // R6
  AST_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst) $fell(limit_on) |-> ($past(ctl_rdata[6]) || !$past(ctl_rdata[5]))); // R7
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst) (limit_on && ctl_rdata[5] && !ctl_rdata[6]) |=> limit_on); // R8
  AST_RDATA_ZEROS: assert property (@(posedge clk) disable iff (rst) (ctl_rdata & 8'h9F) == 8'h00); // R9
endmodule

bind thermal_limiter thermal_limiter_chk #(.QUAL_TICKS(QUAL_TICKS), .LIM_W(LIM_W)) u_chk (
  .clk(clk), .rst(rst), .tick_ms(tick_ms), .warn_s(sync_q[1]), .ctl_rdata(ctl_rdata),
  .lim_coef(lim_coef), .limit_on(limit_on), .limit_val(limit_val), .cnt(cnt)
);

// File: tb/test_thermal_limiter.sv
module test_thermal_limiter;
  localparam int Q = 400;
  localparam int W = 24;

  logic clk = 0, rst = 1, tick_ms = 0, warn_n = 1, ctl_we = 0;
  logic [7:0] ctl_wdata = 0;
  logic [W-1:0] lim_coef = 24'h5A_A000;
  logic [7:0] ctl_rdata;
  logic limit_on;
  logic [W-1:0] limit_val;

  thermal_limiter #(.QUAL_TICKS(Q), .LIM_W(W)) i_thermal_limiter (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .warn_n(warn_n), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .lim_coef(lim_coef), .ctl_rdata(ctl_rdata),
    .limit_on(limit_on), .limit_val(limit_val));

  always #2 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  bit armed = 0, done = 0;
  string cur_req = "R1";

  // behavioural reference
  bit m_adj, m_lat, m_lim;
  bit wq[$];
  int m_ticks;
  logic [W-1:0] m_val;

  always @(posedge clk) begin
    bit w_now, old_lim;
    cyc++;
    if (rst) begin
      m_adj = 1; m_lat = 1; m_lim = 0; m_ticks = 0; m_val = '1;
      wq = '{1'b1, 1'b1};
    end else begin
      w_now = (wq[0] == 1'b0);
      old_lim = m_lim;
      if (m_adj) begin m_lim = 0; m_ticks = 0; end
      else if (m_lim) begin
        if (!w_now && !m_lat) m_lim = 0;
        m_ticks = 0;
      end else if (!w_now) m_ticks = 0;
      else if (tick_ms) begin
        m_ticks++;
        if (m_ticks > Q) begin m_lim = 1; m_ticks = 0; end
      end
      m_val = m_lim ? lim_coef : '1;
      if (ctl_we) begin m_adj = ctl_wdata[6]; m_lat = ctl_wdata[5]; end
      void'(wq.pop_front());
      wq.push_back(warn_n);
      if (old_lim) ;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (armed && !done) begin
    chk(cur_req, "limit_on", {31'b0, limit_on}, {31'b0, m_lim});
    chk(cur_req, "limit_val", {8'b0, limit_val}, {8'b0, m_val});
    chk("R9", "ctl_rdata", {24'b0, ctl_rdata}, {24'b0, 1'b0, m_adj, m_lat, 5'b0});
  end

  task automatic run(input int n, input int tick_every);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_ms = (tick_every > 0) && (i % tick_every == 0);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); ctl_we = 1; ctl_wdata = d; tick_ms = 0;
    @(negedge clk); ctl_we = 0;
  endtask

  always @(posedge clk) if (cyc > 150000 && !done) begin
    done = 1; errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0; armed = 1;
    @(negedge clk);
    cur_req = "R1";
    chk("R1", "reset rdata", {24'b0, ctl_rdata}, 32'h60);
    chk("R1", "reset limit", {31'b0, limit_on}, 0);
    chk("R1", "reset value", {8'b0, limit_val}, 32'hFF_FFFF);

    cur_req = "R6"; warn_n = 0; run(Q + 60, 1);
    chk("R6", "bypassed no limit", {31'b0, limit_on}, 0);
    warn_n = 1; run(5, 1);

    cur_req = "R2"; wr(8'h00); warn_n = 0; run(Q + 2, 1);
    chk("R2", "not yet at edge", {31'b0, limit_on}, 0);
    run(3, 1);
    chk("R2", "limit after qualify", {31'b0, limit_on}, 1);
    cur_req = "R5"; lim_coef = 24'h123456; run(3, 1);
    chk("R5", "coef follows", {8'b0, limit_val}, 32'h123456);
    cur_req = "R7"; warn_n = 1; run(4, 1);
    chk("R7", "released", {31'b0, limit_on}, 0);
    chk("R7", "full scale", {8'b0, limit_val}, 32'hFF_FFFF);

    cur_req = "R3"; warn_n = 0; run(Q - 50, 1);
    warn_n = 1; run(1, 1); warn_n = 0; run(Q - 10, 1);
    chk("R3", "restart no limit", {31'b0, limit_on}, 0);
    run(40, 1);
    chk("R3", "limit after fresh window", {31'b0, limit_on}, 1);
    warn_n = 1; run(5, 1);

    cur_req = "R4"; warn_n = 0; run(Q + 200, 0);
    chk("R4", "no ticks no limit", {31'b0, limit_on}, 0);
    run(4 * Q + 20, 4);
    chk("R4", "sparse ticks qualify", {31'b0, limit_on}, 1);
    warn_n = 1; run(5, 1);

    cur_req = "R8"; wr(8'h20); warn_n = 0; run(Q + 10, 1);
    warn_n = 1; run(50, 1);
    chk("R8", "latched", {31'b0, limit_on}, 1);
    wr(8'h00); run(3, 1);
    chk("R8", "released by write", {31'b0, limit_on}, 0);

    cur_req = "R6"; warn_n = 0; run(Q + 10, 1);
    chk("R6", "armed before bypass", {31'b0, limit_on}, 1);
    wr(8'h40); run(2, 1);
    chk("R6", "bypass drops limit", {31'b0, limit_on}, 0);
    wr(8'h00); run(Q - 5, 1);
    chk("R6", "timer was cleared", {31'b0, limit_on}, 0);
    warn_n = 1; run(5, 1);

    cur_req = "R9"; wr(8'hFF); run(2, 1);
    chk("R9", "only bits 6,5", {24'b0, ctl_rdata}, 32'h60);
    wr(8'h9F); run(2, 1);
    chk("R9", "other bits ignored", {24'b0, ctl_rdata}, 32'h00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule